// File: doc/BRIEF.md
# DMA Request Boundary Splitter

This block accepts one large DMA transfer (a source address, a destination address, a byte length and a direction) and breaks it into a series of memory requests that a PCIe-style link may legally carry. Each request is cut at the next 4 KB host-address boundary and is held under a size limit that depends on its direction. The write limit and the read limit are programmed separately. The host address is the destination of a write and the source of a read, and it is the address that is split. The local address moves forward in step with it.

Each read request takes a small tag from a free pool. The tag records the local base address of the request and the number of bytes still owed to it. Completions may come back in any order and in pieces. Each piece is written straight to its own local address (tag base plus byte offset), and no data is reordered. A tag goes back to the pool once its bytes are all in. While every tag is in use, no new read request is offered. A one-cycle done pulse marks the end of the transfer. It comes after the last request has been taken and every tag has been released.

Top module: `xfer_chunker`

## Requirements
- R1: No emitted request crosses a 4096-byte host-address boundary: (sub_host mod 4096) + sub_len <= 4096.
- R2: A write request (sub_dir = 0) carries at most 128 << cfg_wr_max bytes. Codes 6 and 7 act as code 5, which is 4096 bytes.
- R3: A read request (sub_dir = 1) carries at most 128 << cfg_rd_max bytes, under the same clamping. The limit is independent of cfg_wr_max.
- R4: Each request length is the smallest of three values: the bytes remaining, the direction's limit and the distance to the next 4 KB boundary. Requests come out in ascending order with contiguous host and local addresses, and their lengths add up to req_len. A read takes its host address from req_src and its local address from req_dst. A write does the reverse.
- R5: Each read request carries a tag that is not held by any outstanding read request.
- R6: While all NTAG tags are outstanding, sub_valid stays low.
- R7: A completion on an outstanding tag produces exactly one local write in the next cycle. Its wr_addr is the tag's local base plus cpl_offset, and wr_bytes and wr_data are copied from the completion. This holds whatever order completions arrive in.
- R8: A tag is released, and may be reused, once its completions have covered all of its bytes.
- R9: A completion whose tag is not outstanding is ignored: wr_valid stays low in the next cycle.
- R10: req_ready is high only while the block is idle. done is a single-cycle pulse, raised only after the last request has been accepted and no tag is outstanding.
- R11: While sub_valid is high and sub_ready is low, sub_valid stays high and sub_host, sub_loc, sub_len and sub_dir hold their values.
- R12: In the cycle after reset, req_ready is 1 and sub_valid, wr_valid and done are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr_max | input | 3 | Write size code, limit 128 << code bytes |
| cfg_rd_max | input | 3 | Read size code, limit 128 << code bytes |
| req_valid | input | 1 | Transfer request present |
| req_ready | output | 1 | Block idle, request accepted |
| req_dir | input | 1 | 0 = write to host, 1 = read from host |
| req_src | input | 32 | Source byte address |
| req_dst | input | 32 | Destination byte address |
| req_len | input | 21 | Byte length, whole dwords, at least 4 |
| sub_valid | output | 1 | Split request offered |
| sub_ready | input | 1 | Split request taken |
| sub_dir | output | 1 | Direction of the split request |
| sub_host | output | 32 | Host byte address of the split request |
| sub_loc | output | 32 | Local byte address of the split request |
| sub_len | output | 13 | Byte length of the split request |
| sub_tag | output | TAG_W | Tag of a read request, zero for writes |
| cpl_valid | input | 1 | Read completion piece present |
| cpl_tag | input | TAG_W | Tag the piece belongs to |
| cpl_offset | input | 12 | Byte offset of the piece inside its request |
| cpl_bytes | input | 13 | Byte count of the piece |
| cpl_data | input | DATA_W | Completion data beat |
| wr_valid | output | 1 | Local write strobe |
| wr_addr | output | 32 | Local byte address of the write |
| wr_bytes | output | 13 | Byte count of the write |
| wr_data | output | DATA_W | Write data beat |
| done | output | 1 | Transfer finished pulse |

## Verification
The assertions check the per-cycle rules on every cycle. These are the boundary and limit bounds on the offered request, the hold rule under backpressure, the read stall when the pool is full, the choice of a free tag, the one-to-one link between accepted completions and local writes, and done appearing only with an empty pool. Other behaviour depends on a whole transfer and shows only in the bench's scenarios: that the lengths are the exact three-way minimum, that the addresses are contiguous across boundaries, that local write addresses stay correct when completions come back last-issued first and in pieces, that tags are released and reused, and that done comes exactly once. The bench sweeps starting offsets next to a 4 KB boundary, lengths from one dword to several pages, and all eight size codes in both directions, with and without backpressure.

// File: rtl/chunk_pkg.sv
package chunk_pkg;

    localparam int ADDR_W     = 32;
    localparam int LEN_W      = 21;
    localparam int CHUNK_W    = 13;
    localparam int PAGE_W     = 12;
    localparam int PAGE_BYTES = 1 << PAGE_W;
    localparam int BASE_BYTES = 128;
    localparam int MAX_CODE   = 5;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_DRAIN = 2'd2
    } phase_t;

    typedef enum logic {
        DIR_WR = 1'b0,
        DIR_RD = 1'b1
    } dir_t;

    // Transfer still being split
    typedef struct packed {
        dir_t              dir;
        logic [ADDR_W-1:0] host;
        logic [ADDR_W-1:0] loc;
        logic [LEN_W-1:0]  rem;
    } xfer_t;

    // Bookkeeping of one read tag
    typedef struct packed {
        logic [ADDR_W-1:0]  base;
        logic [CHUNK_W-1:0] left;
    } tag_entry_t;

    function automatic logic [CHUNK_W-1:0] limit_bytes(input logic [2:0] code);
        if (code > 3'(MAX_CODE))
            return CHUNK_W'(PAGE_BYTES);
        return CHUNK_W'(BASE_BYTES) << code;
    endfunction

    function automatic logic [CHUNK_W-1:0] min_bytes(input logic [CHUNK_W-1:0] a,
                                                     input logic [CHUNK_W-1:0] b);
        return (a < b) ? a : b;
    endfunction

endpackage

// File: rtl/chunk_calc.sv
module chunk_calc
    import chunk_pkg::*;
(
    input  xfer_t               cur,
    input  logic [2:0]          wr_code,
    input  logic [2:0]          rd_code,
    output logic [CHUNK_W-1:0]  len,
    output logic                last
);

    logic [CHUNK_W-1:0] lim;
    logic [CHUNK_W-1:0] gap;
    logic [CHUNK_W-1:0] rem_c;

    always_comb begin
        lim   = limit_bytes((cur.dir == DIR_RD) ? rd_code : wr_code);
        gap   = CHUNK_W'(PAGE_BYTES) - {1'b0, cur.host[PAGE_W-1:0]};
        rem_c = (cur.rem > LEN_W'(PAGE_BYTES)) ? CHUNK_W'(PAGE_BYTES)
                                               : cur.rem[CHUNK_W-1:0];
        len   = min_bytes(min_bytes(rem_c, lim), gap);
        last  = (cur.rem == LEN_W'(len));
    end

endmodule

// File: rtl/tag_pool.sv
module tag_pool
    import chunk_pkg::*;
#(
    parameter int NTAG   = 4,
    parameter int TAG_W  = (NTAG > 1) ? $clog2(NTAG) : 1,
    parameter int DATA_W = 256
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               alloc,
    input  logic [ADDR_W-1:0]  alloc_base,
    input  logic [CHUNK_W-1:0] alloc_len,
    output logic               avail,
    output logic [TAG_W-1:0]   free_tag,
    output logic [NTAG-1:0]    busy,
    input  logic               cpl_valid,
    input  logic [TAG_W-1:0]   cpl_tag,
    input  logic [PAGE_W-1:0]  cpl_offset,
    input  logic [CHUNK_W-1:0] cpl_bytes,
    input  logic [DATA_W-1:0]  cpl_data,
    output logic               wr_valid,
    output logic [ADDR_W-1:0]  wr_addr,
    output logic [CHUNK_W-1:0] wr_bytes,
    output logic [DATA_W-1:0]  wr_data
);

    tag_entry_t tbl [NTAG];
    logic       hit;

    // Lowest-numbered free tag
    always_comb begin
        avail    = 1'b0;
        free_tag = '0;
        for (int i = NTAG - 1; i >= 0; i--) begin
            if (!busy[i]) begin
                avail    = 1'b1;
                free_tag = TAG_W'(i);
            end
        end
    end

    assign hit = cpl_valid && (32'(cpl_tag) < NTAG) && busy[cpl_tag];

    always_ff @(posedge clk) begin
        if (rst) begin
            busy     <= '0;
            wr_valid <= 1'b0;
            wr_addr  <= '0;
            wr_bytes <= '0;
            wr_data  <= '0;
        end else begin
            wr_valid <= hit;
            if (hit) begin
                wr_addr  <= tbl[cpl_tag].base + ADDR_W'(cpl_offset);
                wr_bytes <= cpl_bytes;
                wr_data  <= cpl_data;
                tbl[cpl_tag].left <= tbl[cpl_tag].left - cpl_bytes;
                if (tbl[cpl_tag].left <= cpl_bytes)
                    busy[cpl_tag] <= 1'b0;
            end
            if (alloc) begin
                busy[free_tag]      <= 1'b1;
                tbl[free_tag].base  <= alloc_base;
                tbl[free_tag].left  <= alloc_len;
            end
        end
    end

endmodule

// File: rtl/xfer_chunker.sv
module xfer_chunker
    import chunk_pkg::*;
#(
    parameter int NTAG   = 4,
    parameter int TAG_W  = (NTAG > 1) ? $clog2(NTAG) : 1,
    parameter int DATA_W = 256
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [2:0]         cfg_wr_max,
    input  logic [2:0]         cfg_rd_max,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic               req_dir,
    input  logic [31:0]        req_src,
    input  logic [31:0]        req_dst,
    input  logic [20:0]        req_len,
    output logic               sub_valid,
    input  logic               sub_ready,
    output logic               sub_dir,
    output logic [31:0]        sub_host,
    output logic [31:0]        sub_loc,
    output logic [12:0]        sub_len,
    output logic [TAG_W-1:0]   sub_tag,
    input  logic               cpl_valid,
    input  logic [TAG_W-1:0]   cpl_tag,
    input  logic [11:0]        cpl_offset,
    input  logic [12:0]        cpl_bytes,
    input  logic [DATA_W-1:0]  cpl_data,
    output logic               wr_valid,
    output logic [31:0]        wr_addr,
    output logic [12:0]        wr_bytes,
    output logic [DATA_W-1:0]  wr_data,
    output logic               done
);

    phase_t             state;
    xfer_t              cur;
    logic [CHUNK_W-1:0] nxt_len;
    logic               nxt_last;
    logic               tag_avail;
    logic [TAG_W-1:0]   free_tag;
    logic [NTAG-1:0]    tag_busy;
    logic               fire;
    logic               alloc;

    chunk_calc u_calc (
        .cur     (cur),
        .wr_code (cfg_wr_max),
        .rd_code (cfg_rd_max),
        .len     (nxt_len),
        .last    (nxt_last)
    );

    tag_pool #(
        .NTAG   (NTAG),
        .TAG_W  (TAG_W),
        .DATA_W (DATA_W)
    ) u_pool (
        .clk        (clk),
        .rst        (rst),
        .alloc      (alloc),
        .alloc_base (cur.loc),
        .alloc_len  (nxt_len),
        .avail      (tag_avail),
        .free_tag   (free_tag),
        .busy       (tag_busy),
        .cpl_valid  (cpl_valid),
        .cpl_tag    (cpl_tag),
        .cpl_offset (cpl_offset),
        .cpl_bytes  (cpl_bytes),
        .cpl_data   (cpl_data),
        .wr_valid   (wr_valid),
        .wr_addr    (wr_addr),
        .wr_bytes   (wr_bytes),
        .wr_data    (wr_data)
    );

    assign req_ready = (state == ST_IDLE);
    assign sub_valid = (state == ST_ISSUE) && ((cur.dir == DIR_WR) || tag_avail);
    assign sub_dir   = cur.dir;
    assign sub_host  = cur.host;
    assign sub_loc   = cur.loc;
    assign sub_len   = nxt_len;
    assign sub_tag   = (cur.dir == DIR_RD) ? free_tag : '0;
    assign fire      = sub_valid && sub_ready;
    assign alloc     = fire && (cur.dir == DIR_RD);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            cur   <= '0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        cur.dir  <= dir_t'(req_dir);
                        cur.host <= req_dir ? req_src : req_dst;
                        cur.loc  <= req_dir ? req_dst : req_src;
                        cur.rem  <= req_len;
                        state    <= (req_len == '0) ? ST_DRAIN : ST_ISSUE;
                    end
                end
                ST_ISSUE: begin
                    if (fire) begin
                        cur.host <= cur.host + ADDR_W'(nxt_len);
                        cur.loc  <= cur.loc + ADDR_W'(nxt_len);
                        cur.rem  <= cur.rem - LEN_W'(nxt_len);
                        if (nxt_last)
                            state <= ST_DRAIN;
                    end
                end
                ST_DRAIN: begin
                    if (tag_busy == '0) begin
                        done  <= 1'b1;
                        state <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/xfer_chunker_chk.sv
module xfer_chunker_chk
    import chunk_pkg::*;
#(
    parameter int NTAG  = 4,
    parameter int TAG_W = 2
) (
    input logic             clk,
    input logic             rst,
    input logic [2:0]       cfg_wr_max,
    input logic [2:0]       cfg_rd_max,
    input logic             req_ready,
    input logic             sub_valid,
    input logic             sub_ready,
    input logic             sub_dir,
    input logic [31:0]      sub_host,
    input logic [31:0]      sub_loc,
    input logic [12:0]      sub_len,
    input logic [TAG_W-1:0] sub_tag,
    input logic             cpl_valid,
    input logic [TAG_W-1:0] cpl_tag,
    input logic             wr_valid,
    input logic             done,
    input logic [NTAG-1:0]  tag_busy
);

    // R1
    cross_4k_chk: assert property (@(posedge clk) disable iff (rst)
        sub_valid |-> (({1'b0, sub_host[11:0]} + sub_len) <= 13'd4096));

    // R2
    wr_limit_chk: assert property (@(posedge clk) disable iff (rst)
        (sub_valid && !sub_dir) |-> (sub_len <= limit_bytes(cfg_wr_max)));

    // R3
    rd_limit_chk: assert property (@(posedge clk) disable iff (rst)
        (sub_valid && sub_dir) |-> (sub_len <= limit_bytes(cfg_rd_max)));

    // R4
    nonzero_len_chk: assert property (@(posedge clk) disable iff (rst)
        sub_valid |-> (sub_len != '0 && sub_len[1:0] == 2'b00));

    // R5
    free_tag_chk: assert property (@(posedge clk) disable iff (rst)
        (sub_valid && sub_ready && sub_dir) |-> !tag_busy[sub_tag]);

    // R5
    tag_taken_chk: assert property (@(posedge clk) disable iff (rst)
        (sub_valid && sub_ready && sub_dir) |=> tag_busy[$past(sub_tag)]);

    // R6
    stall_chk: assert property (@(posedge clk) disable iff (rst)
        (&tag_busy) |-> !(sub_valid && sub_dir));

    // R7
    cpl_write_chk: assert property (@(posedge clk) disable iff (rst)
        (cpl_valid && tag_busy[cpl_tag]) |=> wr_valid);

    // R9
    cpl_ignore_chk: assert property (@(posedge clk) disable iff (rst)
        !(cpl_valid && tag_busy[cpl_tag]) |=> !wr_valid);

    // R10
    done_empty_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> (tag_busy == '0 && req_ready));

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R11
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        (sub_valid && !sub_ready) |=>
            (sub_valid && $stable(sub_host) && $stable(sub_loc)
             && $stable(sub_len) && $stable(sub_dir)));

    // R12
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (req_ready && !sub_valid && !wr_valid && !done));

endmodule

bind xfer_chunker xfer_chunker_chk #(
    .NTAG  (NTAG),
    .TAG_W (TAG_W)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .cfg_wr_max (cfg_wr_max),
    .cfg_rd_max (cfg_rd_max),
    .req_ready  (req_ready),
    .sub_valid  (sub_valid),
    .sub_ready  (sub_ready),
    .sub_dir    (sub_dir),
    .sub_host   (sub_host),
    .sub_loc    (sub_loc),
    .sub_len    (sub_len),
    .sub_tag    (sub_tag),
    .cpl_valid  (cpl_valid),
    .cpl_tag    (cpl_tag),
    .wr_valid   (wr_valid),
    .done       (done),
    .tag_busy   (tag_busy)
);

// File: tb/xfer_chunker_test.sv
`timescale 1ns/100ps
module xfer_chunker_test;

    localparam int NTAG  = 4;
    localparam int TAG_W = 2;
    localparam int DW    = 256;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [2:0]        cfg_wr_max = '0;
    logic [2:0]        cfg_rd_max = '0;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic              req_dir = 1'b0;
    logic [31:0]       req_src = '0;
    logic [31:0]       req_dst = '0;
    logic [20:0]       req_len = '0;
    logic              sub_valid;
    logic              sub_ready = 1'b1;
    logic              sub_dir;
    logic [31:0]       sub_host;
    logic [31:0]       sub_loc;
    logic [12:0]       sub_len;
    logic [TAG_W-1:0]  sub_tag;
    logic              cpl_valid = 1'b0;
    logic [TAG_W-1:0]  cpl_tag = '0;
    logic [11:0]       cpl_offset = '0;
    logic [12:0]       cpl_bytes = '0;
    logic [DW-1:0]     cpl_data = '0;
    logic              wr_valid;
    logic [31:0]       wr_addr;
    logic [12:0]       wr_bytes;
    logic [DW-1:0]     wr_data;
    logic              done;

    always #2 clk = ~clk;

    xfer_chunker #(.NTAG(NTAG), .TAG_W(TAG_W), .DATA_W(DW)) uut (
        .clk(clk), .rst(rst), .cfg_wr_max(cfg_wr_max), .cfg_rd_max(cfg_rd_max),
        .req_valid(req_valid), .req_ready(req_ready), .req_dir(req_dir),
        .req_src(req_src), .req_dst(req_dst), .req_len(req_len),
        .sub_valid(sub_valid), .sub_ready(sub_ready), .sub_dir(sub_dir),
        .sub_host(sub_host), .sub_loc(sub_loc), .sub_len(sub_len), .sub_tag(sub_tag),
        .cpl_valid(cpl_valid), .cpl_tag(cpl_tag), .cpl_offset(cpl_offset),
        .cpl_bytes(cpl_bytes), .cpl_data(cpl_data),
        .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_bytes(wr_bytes),
        .wr_data(wr_data), .done(done)
    );

    int checks = 0;
    int errors = 0;

    int unsigned e_host [0:1023];
    int unsigned e_loc  [0:1023];
    int unsigned e_len  [0:1023];
    int unsigned t_left [NTAG];
    int unsigned t_len  [NTAG];
    int unsigned t_base [NTAG];
    int          stk    [0:15];
    logic [31:0] seqv = 32'h1000;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic run_xfer(input bit rd, input int unsigned src, input int unsigned dst,
                            input int unsigned len, input int wrc, input int rdc,
                            input int mode);
        int unsigned lim, h, l, rem, c, gap;
        int n, idx, sp, dones, code;
        bit wexp, hold;
        int unsigned w_addr, w_bytes, h_host, h_len;
        logic [DW-1:0] w_data;
        string lreq;
        code = rd ? rdc : wrc;
        lim  = (code > 5) ? 4096 : (128 << code);
        lreq = rd ? "R3" : "R2";
        n = 0; h = rd ? src : dst; l = rd ? dst : src; rem = len;
        while (rem > 0) begin
            gap = 4096 - (h % 4096);
            c = rem;
            if (lim < c) c = lim;
            if (gap < c) c = gap;
            e_host[n] = h; e_loc[n] = l; e_len[n] = c;
            h += c; l += c; rem -= c; n++;
        end
        for (int t = 0; t < NTAG; t++) t_left[t] = 0;
        @(negedge clk);
        cfg_wr_max = 3'(wrc); cfg_rd_max = 3'(rdc);
        req_dir = rd; req_src = src; req_dst = dst; req_len = 21'(len);
        req_valid = 1'b1;
        check(req_ready, "R10", "req_ready idle", req_ready, 1);
        @(negedge clk);
        req_valid = 1'b0;
        check(!req_ready, "R10", "req_ready busy", req_ready, 0);
        idx = 0; sp = 0; dones = 0; wexp = 0; hold = 0;
        w_addr = 0; w_bytes = 0; w_data = '0; h_host = 0; h_len = 0;
        for (int cyc = 0; cyc < 20000; cyc++) begin
            if (wexp) begin
                check(wr_valid && wr_addr == w_addr && wr_bytes == 13'(w_bytes)
                      && wr_data == w_data, "R7", "local write addr",
                      {wr_valid, wr_addr}, {1'b1, w_addr});
            end else begin
                check(!wr_valid, "R9", "no stray write", wr_valid, 0);
            end
            wexp = 0;
            if (done) begin
                dones++;
                check(idx == n && sp == 0, "R10", "done after drain", idx, n);
                break;
            end
            sub_ready = (mode == 0) ? 1'b1 : ((cyc % 3) != 1);
            cpl_valid = 1'b0;
            #1;
            if (hold) begin
                check(sub_valid && sub_host == h_host && sub_len == 13'(h_len),
                      "R11", "held request", sub_host, h_host);
            end
            hold = sub_valid && !sub_ready;
            h_host = sub_host; h_len = sub_len;
            if (rd && sp == NTAG)
                check(!sub_valid, "R6", "stall when pool full", sub_valid, 0);
            if (sub_valid && sub_ready) begin
                check(idx < n, "R4", "extra request", idx, n);
                if (idx < n) begin
                    check(sub_host == e_host[idx] && sub_loc == e_loc[idx]
                          && sub_dir == rd, "R4", "request address",
                          sub_host, e_host[idx]);
                    check(sub_len == 13'(e_len[idx]), lreq, "request length",
                          sub_len, e_len[idx]);
                    check(sub_len + (sub_host % 4096) <= 4096, "R1", "4K crossing",
                          sub_len + (sub_host % 4096), 4096);
                    if (rd) begin
                        check(t_left[sub_tag] == 0, "R5", "tag reuse while busy",
                              t_left[sub_tag], 0);
                        t_left[sub_tag] = e_len[idx];
                        t_len[sub_tag]  = e_len[idx];
                        t_base[sub_tag] = e_loc[idx];
                        stk[sp] = int'(sub_tag);
                        sp++;
                    end
                end
                idx++;
            end else if (rd && sp > 0 && (sp == NTAG || idx == n)) begin
                int tg;
                int unsigned piece;
                tg = stk[sp-1];
                piece = (t_left[tg] < 64) ? t_left[tg] : 64;
                cpl_valid  = 1'b1;
                cpl_tag    = TAG_W'(tg);
                cpl_offset = 12'(t_len[tg] - t_left[tg]);
                cpl_bytes  = 13'(piece);
                cpl_data   = {(DW/32){seqv}};
                wexp = 1; w_addr = t_base[tg] + (t_len[tg] - t_left[tg]);
                w_bytes = piece; w_data = {(DW/32){seqv}};
                seqv = seqv + 1;
                t_left[tg] -= piece;
                if (t_left[tg] == 0) sp--;
            end
            @(negedge clk);
        end
        cpl_valid = 1'b0;
        sub_ready = 1'b1;
        check(dones == 1, "R10", "done seen once", dones, 1);
        check(idx == n, "R8", "all requests issued, tags recycled", idx, n);
        for (int k = 0; k < 2; k++) begin
            @(negedge clk);
            check(!done && req_ready, "R10", "single done pulse", done, 0);
        end
    endtask

    initial begin
        #(4 * 190000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int unsigned offs [3];
        int unsigned lens [4];
        offs = '{32'h0, 32'hFFC, 32'h7F0};
        lens = '{4, 128, 4100, 9000};
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(req_ready && !sub_valid && !wr_valid && !done, "R12", "reset state",
              {req_ready, sub_valid, wr_valid, done}, 4'b1000);
        // Completion on a free tag must be dropped
        cpl_valid = 1'b1; cpl_tag = 2'd1; cpl_offset = 12'h10; cpl_bytes = 13'd16;
        @(negedge clk);
        cpl_valid = 1'b0;
        check(!wr_valid, "R9", "completion on free tag", wr_valid, 0);
        for (int o = 0; o < 3; o++) begin
            for (int li = 0; li < 4; li++) begin
                for (int code = 0; code < 8; code++) begin
                    run_xfer(1'b0, 32'h0000_0100 + 32'(o * 4), 32'h1000_0000 + offs[o],
                             lens[li], code, 7 - code, code % 2);
                    run_xfer(1'b1, 32'h3000_0040 + offs[o], 32'h0000_8000 + 32'(o * 4),
                             lens[li], 7 - code, code, (code / 2) % 2);
                end
            end
        end
        // Tag pool empty after all transfers: stray completion still ignored
        @(negedge clk);
        cpl_valid = 1'b1; cpl_tag = 2'd3; cpl_offset = 12'h0; cpl_bytes = 13'd4;
        @(negedge clk);
        cpl_valid = 1'b0;
        check(!wr_valid, "R9", "completion after release", wr_valid, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule